// File: doc/BRIEF.md
# Three-Channel Timer Host Register Front End

This block is the byte-wide host side of a three-channel timer. A 3-bit register select together with separate write and read strobes reaches three control registers, a shared high-byte staging register, the three timers' reload latches, their running counters and a status byte. Control registers one and three share a single write address. Bit 0 of control register two decides which of the two that address reaches.

The counters and channel sequencers sit outside this block. They receive the control bytes and a one-cycle reload strobe with its 16-bit value. In return they supply their counter values, a per-channel timeout event that raises an interrupt flag, and a per-channel counter-initialization event. The block holds the three interrupt flags and combines them with each channel's enable bit into one active-high request. It also runs the clearing rule for the flags. A flag clears when the host reads the status byte while that flag is set and later reads the matching counter. The block also divides timer three's clock enable by a parameterized prescale factor when control register three asks for it.

Top module: `tmr_regif`

## Requirements
- R1: A write to select 0 loads control register one when bit 0 of control register two is 1, and loads control register three when that bit is 0. A read of select 0 returns 0x00 and changes no register.
- R2: A write to select 1 loads control register two. A read of select 1 returns the status byte.
- R3: A write to select 2, 4 or 6 loads the shared high-byte staging register. A read of select 2, 4 or 6 returns the high byte of counter 1, 2 or 3 on `rdata_o` in the cycle after the read strobe.
- R4: A write to select 3, 5 or 7 raises bit 0, 1 or 2 of `latch_load_o` for exactly one cycle, starting the cycle after the write. `latch_val_o` then carries {staging byte, written byte}. A read of any of these selects returns the low-byte buffer and leaves it unchanged.
- R5: Reading a counter's high byte stores that counter's low byte in the low-byte buffer in the same cycle, so the next odd-select read returns the low byte from the same instant.
- R6: Status bits 2:0 are the flags of timers 3 to 1, and bits 6:3 read 0. Bit 7 is set when any flag is set whose channel has bit 6 of its control register set. `irq_o` equals status bit 7.
- R7: A flag clears after a status read that sees it set, followed later by a read of that timer's counter. A counter read with no such earlier status read leaves the flag set.
- R8: A `tmo_i` pulse sets a flag. A latch write or an `init_i` pulse for the same channel clears it, and a set in the same cycle wins over these. While bit 0 of control register one is 1, all flags are held clear and cannot be set.
- R9: With bit 0 of control register three at 1, `clk3_en_o` passes only every PRESCALE-th `clk3_en_i` pulse. With that bit at 0, it copies `clk3_en_i`.
- R10: After reset, all control registers, `rdata_o`, `latch_load_o`, the flags and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| sel | input | 3 | Register select |
| wdata | input | 8 | Host write byte |
| rdata_o | output | 8 | Registered read byte |
| cnt_i | input | 3x16 | Counter values of timers 3..1 |
| tmo_i | input | 3 | Per-channel timeout event, sets flag |
| init_i | input | 3 | Per-channel counter initialization, clears flag |
| clk3_en_i | input | 1 | Timer three clock enable before prescale |
| clk3_en_o | output | 1 | Timer three clock enable after prescale |
| ctl1_o | output | 8 | Control register one |
| ctl2_o | output | 8 | Control register two |
| ctl3_o | output | 8 | Control register three |
| latch_load_o | output | 3 | One-hot reload strobe per timer |
| latch_val_o | output | 16 | Reload value |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
The bench builds the block with its default PRESCALE of 8. At that value a burst of sixteen enable pulses gives an exact count of two passed pulses, so an off-by-one in the prescaler counter shows up as a wrong count. The three counter inputs hold distinct constant patterns, so every byte read back identifies which counter and which half it came from. The flag tests mix enabled and masked channels, which lets one status read tell the flag bits apart from the request bit.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
    parameter int unsigned DW  = 8;
    parameter int unsigned NCH = 3;
    parameter int unsigned SW  = 3;
    localparam int unsigned CW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0]  ctl1;
        logic [DW-1:0]  ctl2;
        logic [DW-1:0]  ctl3;
        logic [DW-1:0]  msb;
        logic [DW-1:0]  lsb;
        logic [DW-1:0]  rdata;
        logic [NCH-1:0] load;
        logic [CW-1:0]  lval;
    } host_state_t;
endpackage

// File: rtl/tmr_regif_decode.sv
module tmr_regif_decode
    import tmr_regif_pkg::*;
(
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [SW-1:0]  sel,
    output logic           wr_shared,
    output logic           wr_ctl2,
    output logic           wr_msb,
    output logic [NCH-1:0] wr_latch,
    output logic           rd_status,
    output logic           rd_lsb,
    output logic [NCH-1:0] rd_cnt
);
    assign wr_shared = wr_en && (sel == SW'(0));
    assign wr_ctl2   = wr_en && (sel == SW'(1));
    assign rd_status = rd_en && (sel == SW'(1));
    assign wr_msb    = wr_en && (sel > SW'(1)) && !sel[0];
    assign rd_lsb    = rd_en && (sel > SW'(1)) && sel[0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_latch[i] = wr_en && (sel == SW'(2*i+3));
        assign rd_cnt[i]   = rd_en && (sel == SW'(2*i+2));
    end
endmodule

// File: rtl/tmr_regif_flags.sv
module tmr_regif_flags
    import tmr_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic [NCH-1:0] set_ev,
    input  logic [NCH-1:0] init_ev,
    input  logic [NCH-1:0] wr_latch,
    input  logic           rd_status,
    input  logic [NCH-1:0] rd_cnt,
    output logic [NCH-1:0] flag_o
);
    logic [NCH-1:0] flag_d, flag_q;
    logic [NCH-1:0] arm_d, arm_q;

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        always_comb begin
            logic clr;
            clr = init_ev[i] || wr_latch[i] || (rd_cnt[i] && arm_q[i]);
            if (hold)           flag_d[i] = 1'b0;
            else if (set_ev[i]) flag_d[i] = 1'b1;
            else if (clr)       flag_d[i] = 1'b0;
            else                flag_d[i] = flag_q[i];

            if (rd_status) arm_d[i] = flag_q[i];
            else           arm_d[i] = arm_q[i] && flag_d[i] && !rd_cnt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tmr_regif_prescale.sv
module tmr_regif_prescale #(
    parameter int unsigned PRESCALE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_en,
    input  logic en_i,
    output logic en_o
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!div_en)   cnt_d = '0;
        else if (en_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign en_o = div_en ? (en_i && cnt_q == LAST) : en_i;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int unsigned PRESCALE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [SW-1:0]           sel,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata_o,
    input  logic [NCH-1:0][CW-1:0]  cnt_i,
    input  logic [NCH-1:0]          tmo_i,
    input  logic [NCH-1:0]          init_i,
    input  logic                    clk3_en_i,
    output logic                    clk3_en_o,
    output logic [DW-1:0]           ctl1_o,
    output logic [DW-1:0]           ctl2_o,
    output logic [DW-1:0]           ctl3_o,
    output logic [NCH-1:0]          latch_load_o,
    output logic [CW-1:0]           latch_val_o,
    output logic                    irq_o
);
    localparam int unsigned PADW = DW - NCH - 1;

    host_state_t    st_d, st_q;
    logic           wr_shared, wr_ctl2, wr_msb, rd_status, rd_lsb;
    logic [NCH-1:0] wr_latch, rd_cnt;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] ie;
    logic [DW-1:0]  status;
    logic [DW-1:0]  msb_q;

    tmr_regif_decode u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wr_shared(wr_shared), .wr_ctl2(wr_ctl2), .wr_msb(wr_msb),
        .wr_latch(wr_latch), .rd_status(rd_status), .rd_lsb(rd_lsb),
        .rd_cnt(rd_cnt)
    );

    tmr_regif_flags u_flg (
        .clk(clk), .rst_n(rst_n), .hold(st_q.ctl1[0]),
        .set_ev(tmo_i), .init_ev(init_i), .wr_latch(wr_latch),
        .rd_status(rd_status), .rd_cnt(rd_cnt), .flag_o(flag_q)
    );

    tmr_regif_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_en(st_q.ctl3[0]),
        .en_i(clk3_en_i), .en_o(clk3_en_o)
    );

    assign ie     = {st_q.ctl3[6], st_q.ctl2[6], st_q.ctl1[6]};
    assign status = {|(flag_q & ie), {PADW{1'b0}}, flag_q};

    always_comb begin
        st_d      = st_q;
        st_d.load = '0;
        if (wr_shared) begin
            if (st_q.ctl2[0]) st_d.ctl1 = wdata;
            else              st_d.ctl3 = wdata;
        end
        if (wr_ctl2) st_d.ctl2 = wdata;
        if (wr_msb)  st_d.msb  = wdata;
        if (|wr_latch) begin
            st_d.load = wr_latch;
            st_d.lval = {st_q.msb, wdata};
        end
        if (rd_en) begin
            st_d.rdata = '0;
            if (rd_status) st_d.rdata = status;
            if (rd_lsb)    st_d.rdata = st_q.lsb;
            for (int i = 0; i < NCH; i++) begin
                if (rd_cnt[i]) begin
                    st_d.rdata = cnt_i[i][CW-1:DW];
                    st_d.lsb   = cnt_i[i][DW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb_q        = st_q.msb;
    assign rdata_o      = st_q.rdata;
    assign ctl1_o       = st_q.ctl1;
    assign ctl2_o       = st_q.ctl2;
    assign ctl3_o       = st_q.ctl3;
    assign latch_load_o = st_q.load;
    assign latch_val_o  = st_q.lval;
    assign irq_o        = status[DW-1];
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
    import tmr_regif_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic [SW-1:0]  sel,
    input logic [DW-1:0]  wdata,
    input logic [DW-1:0]  rdata_o,
    input logic [DW-1:0]  ctl1_o,
    input logic [DW-1:0]  ctl2_o,
    input logic [DW-1:0]  ctl3_o,
    input logic [NCH-1:0] latch_load_o,
    input logic [NCH-1:0] tmo_i,
    input logic [NCH-1:0] flag_q,
    input logic [DW-1:0]  msb_q,
    input logic           irq_o,
    input logic           clk3_en_i,
    input logic           clk3_en_o
);
    p_sel0_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sel == SW'(0)) |=> (rdata_o == '0 && $stable(ctl1_o) && $stable(ctl2_o) && $stable(ctl3_o)));

    p_msb_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SW'(2)) |=> (msb_q == $past(wdata)));

    p_load_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_load_o));

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_q != '0));

    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_o[0] |=> (flag_q == '0));

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl3_o[0] |-> (clk3_en_o == clk3_en_i));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel == SW'(2*i+3) && !tmo_i[i]) |=> !flag_q[i]);
    end
endmodule

bind tmr_regif tmr_regif_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .wdata(wdata), .rdata_o(rdata_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o),
    .ctl3_o(ctl3_o), .latch_load_o(latch_load_o), .tmo_i(tmo_i),
    .flag_q(flag_q), .msb_q(msb_q), .irq_o(irq_o),
    .clk3_en_i(clk3_en_i), .clk3_en_o(clk3_en_o)
);

// File: tb/tmr_regif_tb_top.sv
module tmr_regif_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [2:0]        sel = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata_o;
    logic [2:0][15:0]  cnt_i;
    logic [2:0]        tmo_i = '0;
    logic [2:0]        init_i = '0;
    logic              clk3_en_i = 1'b0;
    logic              clk3_en_o;
    logic [7:0]        ctl1_o, ctl2_o, ctl3_o;
    logic [2:0]        latch_load_o;
    logic [15:0]       latch_val_o;
    logic              irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    assign cnt_i = {16'hE5F6, 16'hC3D4, 16'hA1B2};

    tmr_regif dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
        .wdata(wdata), .rdata_o(rdata_o), .cnt_i(cnt_i), .tmo_i(tmo_i),
        .init_i(init_i), .clk3_en_i(clk3_en_i), .clk3_en_o(clk3_en_o),
        .ctl1_o(ctl1_o), .ctl2_o(ctl2_o), .ctl3_o(ctl3_o),
        .latch_load_o(latch_load_o), .latch_val_o(latch_val_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [2:0] s;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd1, 8'h01, 1'b0, 8'h00},
        '{1'b1, 1'b0, 3'd0, 8'h42, 1'b0, 8'h00},
        '{1'b1, 1'b0, 3'd1, 8'h00, 1'b0, 8'h00},
        '{1'b1, 1'b0, 3'd0, 8'h81, 1'b0, 8'h00},
        '{1'b1, 1'b0, 3'd1, 8'h40, 1'b0, 8'h00},
        '{1'b0, 1'b1, 3'd2, 8'h00, 1'b1, 8'hA1},
        '{1'b0, 1'b1, 3'd3, 8'h00, 1'b1, 8'hB2},
        '{1'b0, 1'b1, 3'd4, 8'h00, 1'b1, 8'hC3},
        '{1'b0, 1'b1, 3'd5, 8'h00, 1'b1, 8'hD4},
        '{1'b0, 1'b1, 3'd6, 8'h00, 1'b1, 8'hE5},
        '{1'b0, 1'b1, 3'd7, 8'h00, 1'b1, 8'hF6},
        '{1'b0, 1'b1, 3'd0, 8'h00, 1'b1, 8'h00},
        '{1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic pulse_tmo(input int ch);
        @(negedge clk);
        tmo_i[ch] = 1'b1;
        @(negedge clk);
        tmo_i = '0;
    endtask

    task automatic rd_status_chk(input string req, input logic [7:0] exp);
        op(1'b0, 1'b1, 3'd1, 8'h00);
        check(req, 32'(rdata_o), 32'(exp));
    endtask

    task automatic count_pulses(input int n, output int got);
        got = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            clk3_en_i = 1'b1;
            #1;
            if (clk3_en_o) got++;
            @(negedge clk);
            clk3_en_i = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int got;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 rdata", 32'(rdata_o), 32'h0);
        check("R10 ctl", 32'({ctl1_o, ctl2_o, ctl3_o}), 32'h0);
        check("R10 load/irq", 32'({latch_load_o, irq_o}), 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 routing, R2, R3 high bytes, R5 low-byte capture
        for (int v = 0; v < NV; v++) begin
            op(VECS[v].wr, VECS[v].rd, VECS[v].s, VECS[v].wd);
            if (VECS[v].chk)
                check($sformatf("R3/R5/R1/R2 vec %0d", v), 32'(rdata_o), 32'(VECS[v].exp));
        end
        check("R1 ctl1", 32'(ctl1_o), 32'h42);
        check("R1 ctl3", 32'(ctl3_o), 32'h81);
        check("R2 ctl2", 32'(ctl2_o), 32'h40);

        // R4: latch staging and one-cycle strobe
        op(1'b1, 1'b0, 3'd4, 8'h12);
        op(1'b1, 1'b0, 3'd5, 8'h34);
        check("R4 strobe", 32'(latch_load_o), 32'h2);
        check("R4 value", 32'(latch_val_o), 32'h1234);
        @(negedge clk);
        check("R4 strobe width", 32'(latch_load_o), 32'h0);
        op(1'b0, 1'b1, 3'd5, 8'h00);
        check("R4 lsb unchanged", 32'(rdata_o), 32'hF6);

        // R6 / R7: status then counter read clears
        pulse_tmo(1);
        check("R6 irq", 32'(irq_o), 32'h1);
        rd_status_chk("R6 status", 8'h82);
        op(1'b0, 1'b1, 3'd6, 8'h00);
        rd_status_chk("R7 other counter", 8'h82);
        op(1'b0, 1'b1, 3'd4, 8'h00);
        check("R7 counter read", 32'(rdata_o), 32'hC3);
        rd_status_chk("R7 cleared", 8'h00);
        check("R7 irq low", 32'(irq_o), 32'h0);

        // R7 negative: counter read without status read
        pulse_tmo(0);
        op(1'b0, 1'b1, 3'd2, 8'h00);
        rd_status_chk("R7 not armed", 8'h81);
        // R8: latch write clears
        op(1'b1, 1'b0, 3'd3, 8'h00);
        rd_status_chk("R8 latch clear", 8'h00);

        // R6 masked channel, R8 init clear
        pulse_tmo(2);
        check("R6 masked irq", 32'(irq_o), 32'h0);
        rd_status_chk("R6 masked status", 8'h04);
        @(negedge clk);
        init_i[2] = 1'b1;
        @(negedge clk);
        init_i = '0;
        rd_status_chk("R8 init clear", 8'h00);

        // R8: set wins over same-cycle latch write
        @(negedge clk);
        tmo_i[0] = 1'b1; wr_en = 1'b1; sel = 3'd3; wdata = 8'h00;
        @(negedge clk);
        tmo_i = '0; wr_en = 1'b0;
        rd_status_chk("R8 set wins", 8'h81);

        // R8: hold bit clears and blocks setting
        op(1'b1, 1'b0, 3'd1, 8'h41);
        op(1'b1, 1'b0, 3'd0, 8'h43);
        @(negedge clk);
        rd_status_chk("R8 hold clear", 8'h00);
        pulse_tmo(0);
        rd_status_chk("R8 hold blocks", 8'h00);
        op(1'b1, 1'b0, 3'd0, 8'h42);

        // R9: prescaler
        count_pulses(16, got);
        check("R9 divided", 32'(got), 32'd2);
        op(1'b1, 1'b0, 3'd1, 8'h40);
        op(1'b1, 1'b0, 3'd0, 8'h80);
        count_pulses(5, got);
        check("R9 bypass", 32'(got), 32'd5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule